// File: doc/BRIEF.md
# Encoder Ring-Buffer Position and Interrupt Unit

This unit follows the write pointer of a video encoder as it fills a circular region of memory with its compressed output. Each time the encoder signals an advance, the pointer moves forward by the given byte count. When the pointer would reach or pass the end of the region, it folds back to the start and records a wrap event. A programmable alert threshold, formed from an alert position plus an alert offset, raises a level-type alert for as long as the pointer sits at or beyond it. Software uses this to hand off the stream in chunks.

Software sees six register slots through a small read/write port. These hold the region start, the region end, the alert position, the alert offset, a read-only copy of the pointer, and one combined word. The combined word carries status, acknowledge and per-bit disable flags. Two more status sources, a frame-done pulse and an overflow pulse, arrive from neighbouring frame bookkeeping logic and share the same word. All enabled status bits merge into a single interrupt line.

Top module: `encRingIrq`

## Requirements
- R1: After reset every register reads zero and the interrupt is low. The register indices are: 0 region start, 1 region end, 2 alert position, 3 alert offset, 4 pointer, 5 combined word. Indices 6 and 7 read zero. The four writable address registers keep bits 23:0 of the written data, and bits 31:24 read as zero.
- R2: An advance with no start write in the same cycle, whose 25-bit sum of pointer and byte count is below the region end, sets the pointer to that sum on the next cycle.
- R3: When that 25-bit sum is greater than or equal to the region end, the pointer loads the region start and status bit 2 (wrap) is set on the next cycle.
- R4: A write to index 0 loads the written value into the pointer on the next cycle. It takes precedence over an advance in the same cycle, and that advance then sets no wrap flag.
- R5: Writes to index 4 leave the pointer unchanged.
- R6: Status bit 0 (alert) is set on the cycle after any cycle in which the alert offset is nonzero and the pointer is greater than or equal to the 25-bit sum of alert position and alert offset.
- R7: While the alert offset is zero, status bit 0 is never newly set.
- R8: Reading index 5 returns status in bits 7:0 and disable flags in bits 23:16, with all other bits zero. Every write to index 5 stores bits 23:16 as the disable flags.
- R9: Writing 1 to bit 8+k of index 5 clears status bit k on the next cycle. If the alert condition still holds, bit 0 reads zero for one cycle and is set again on the cycle after. A wrap, frame or overflow event in the same cycle as its acknowledge still sets its bit.
- R10: A pulse on `frameSet` sets status bit 1, and a pulse on `ovflSet` sets status bit 3, on the next cycle. Status bits 4 to 7 are never set.
- R11: `irqOut` is high exactly when some status bit is set whose disable flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advValid | input | 1 | Encoder advance strobe |
| advBytes | input | 12 | Bytes written by this advance |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| frameSet | input | 1 | Frame-done event pulse |
| ovflSet | input | 1 | Overflow event pulse |
| irqOut | output | 1 | Merged interrupt |

## Verification
The properties assume that `advBytes` fits in the 25-bit pointer sum without carrying out of it. They also assume that a register write is only meaningful when `regWr` is high, with `regAddr` and `regWrData` ignored otherwise. The stimulus keeps byte counts and region bounds small, so wraps, alert crossings and folds back to start all happen often. The stimulus also deliberately lines up acknowledges with same-cycle events, start writes with advances, and pointer writes with idle cycles. This exercises the precedence rules that the assertions state.

// File: rtl/encRingPkg.sv
package encRingPkg;

  typedef struct packed {
    logic wrStart;
    logic wrEnd;
    logic wrAlertPos;
    logic wrAlertOfs;
    logic advance;
  } ringStrobeT;

  typedef enum logic [2:0] {
    REG_START     = 3'd0,
    REG_END       = 3'd1,
    REG_ALERT_POS = 3'd2,
    REG_ALERT_OFS = 3'd3,
    REG_CUR_POS   = 3'd4,
    REG_CTRL      = 3'd5
  } regIdxT;

  localparam int BIT_ALERT = 0;
  localparam int BIT_FRAME = 1;
  localparam int BIT_WRAP  = 2;
  localparam int BIT_OVFL  = 3;

endpackage

// File: rtl/encRingDatapath.sv
module encRingDatapath
  import encRingPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobeT        strobe,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CNT_W-1:0]  advBytes,
  output logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] endAddr,
  output logic [ADDR_W-1:0] alertPos,
  output logic [ADDR_W-1:0] alertOfs,
  output logic [ADDR_W-1:0] curPos,
  output logic              wrapHit,
  output logic              alertLvl
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] wrVal;
  logic [SUM_W-1:0]  advSum;
  logic [SUM_W-1:0]  alertTarget;

  assign wrVal = regWrData[ADDR_W-1:0];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      endAddr   <= '0;
      alertPos  <= '0;
      alertOfs  <= '0;
    end else begin
      if (strobe.wrStart)    startAddr <= wrVal;
      if (strobe.wrEnd)      endAddr   <= wrVal;
      if (strobe.wrAlertPos) alertPos  <= wrVal;
      if (strobe.wrAlertOfs) alertOfs  <= wrVal;
    end
  end

  // pointer arithmetic, full-width sum so no modular wrap hides a crossing
  always_comb begin
    advSum  = {1'b0, curPos} + SUM_W'(advBytes);
    wrapHit = strobe.advance && !strobe.wrStart && (advSum >= {1'b0, endAddr});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPos <= '0;
    end else if (strobe.wrStart) begin
      curPos <= wrVal;
    end else if (strobe.advance) begin
      curPos <= wrapHit ? startAddr : advSum[ADDR_W-1:0];
    end
  end

  // level alert against position plus offset
  always_comb begin
    alertTarget = {1'b0, alertPos} + {1'b0, alertOfs};
    alertLvl    = (alertOfs != '0) && ({1'b0, curPos} >= alertTarget);
  end

endmodule

// File: rtl/encRingCtrl.sv
module encRingCtrl
  import encRingPkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               advValid,
  input  logic               frameSet,
  input  logic               ovflSet,
  input  logic               wrapHit,
  input  logic               alertLvl,
  output ringStrobeT         strobe,
  output logic [NUM_IRQ-1:0] statusBits,
  output logic [NUM_IRQ-1:0] disableBits,
  output logic               irqOut
);
  localparam int ACK_LO = NUM_IRQ;
  localparam int DIS_LO = 2 * NUM_IRQ;

  logic               ctrlWr;
  logic [NUM_IRQ-1:0] ackMask;
  logic [NUM_IRQ-1:0] setMask;

  always_comb begin
    strobe            = '0;
    strobe.wrStart    = regWr && (regAddr == REG_START);
    strobe.wrEnd      = regWr && (regAddr == REG_END);
    strobe.wrAlertPos = regWr && (regAddr == REG_ALERT_POS);
    strobe.wrAlertOfs = regWr && (regAddr == REG_ALERT_OFS);
    strobe.advance    = advValid;
    ctrlWr            = regWr && (regAddr == REG_CTRL);
  end

  always_comb begin
    ackMask = ctrlWr ? regWrData[ACK_LO +: NUM_IRQ] : '0;
    setMask = '0;
    // an acknowledge of the level alert wins for one cycle
    setMask[BIT_ALERT] = alertLvl && !ackMask[BIT_ALERT];
    setMask[BIT_FRAME] = frameSet;
    setMask[BIT_WRAP]  = wrapHit;
    setMask[BIT_OVFL]  = ovflSet;
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rstN)               statusBits[k] <= 1'b0;
      else if (setMask[k])     statusBits[k] <= 1'b1;
      else if (ackMask[k])     statusBits[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       disableBits <= '0;
    else if (ctrlWr) disableBits <= regWrData[DIS_LO +: NUM_IRQ];
  end

  assign irqOut = |(statusBits & ~disableBits);

endmodule

// File: rtl/encRingIrq.sv
module encRingIrq
  import encRingPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int CNT_W   = 12,
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advValid,
  input  logic [CNT_W-1:0]  advBytes,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              frameSet,
  input  logic              ovflSet,
  output logic              irqOut
);
  ringStrobeT         strobe;
  logic [ADDR_W-1:0]  startAddr, endAddr, alertPos, alertOfs, curPos;
  logic               wrapHit, alertLvl;
  logic [NUM_IRQ-1:0] statusBits, disableBits;

  encRingCtrl #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .advValid(advValid), .frameSet(frameSet),
    .ovflSet(ovflSet), .wrapHit(wrapHit), .alertLvl(alertLvl),
    .strobe(strobe), .statusBits(statusBits), .disableBits(disableBits),
    .irqOut(irqOut)
  );

  encRingDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .advBytes(advBytes), .startAddr(startAddr), .endAddr(endAddr),
    .alertPos(alertPos), .alertOfs(alertOfs), .curPos(curPos),
    .wrapHit(wrapHit), .alertLvl(alertLvl)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_START:     regRdData[ADDR_W-1:0] = startAddr;
      REG_END:       regRdData[ADDR_W-1:0] = endAddr;
      REG_ALERT_POS: regRdData[ADDR_W-1:0] = alertPos;
      REG_ALERT_OFS: regRdData[ADDR_W-1:0] = alertOfs;
      REG_CUR_POS:   regRdData[ADDR_W-1:0] = curPos;
      REG_CTRL: begin
        regRdData[NUM_IRQ-1:0]               = statusBits;
        regRdData[2*NUM_IRQ +: NUM_IRQ]      = disableBits;
      end
      default:       regRdData = '0;
    endcase
  end

endmodule

// File: rtl/encRingIrqChk.sv
module encRingIrqChk #(
  parameter int ADDR_W  = 24,
  parameter int CNT_W   = 12,
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               advValid,
  input logic [CNT_W-1:0]   advBytes,
  input logic               regWr,
  input logic [2:0]         regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               irqOut,
  input logic [ADDR_W-1:0]  curPos,
  input logic [ADDR_W-1:0]  startAddr,
  input logic [ADDR_W-1:0]  endAddr,
  input logic [ADDR_W-1:0]  alertOfs,
  input logic [NUM_IRQ-1:0] statusBits,
  input logic [NUM_IRQ-1:0] disableBits
);
  logic [ADDR_W:0] chkSum;
  assign chkSum = {1'b0, curPos} + (ADDR_W+1)'(advBytes);

  // R3
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advValid && !(regWr && regAddr == 3'd0) && chkSum >= {1'b0, endAddr})
    |=> (curPos == $past(startAddr)) && statusBits[2]);

  // R2
  advance_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advValid && !(regWr && regAddr == 3'd0) && chkSum < {1'b0, endAddr})
    |=> curPos == $past(chkSum[ADDR_W-1:0]));

  // R4
  start_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd0) |=> curPos == $past(regWrData[ADDR_W-1:0]));

  // R5
  ptr_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd4 && !advValid) |=> $stable(curPos));

  // R7
  zero_ofs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alertOfs == '0 && !statusBits[0]) |=> !statusBits[0]);

  // R9
  alert_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd5 && regWrData[NUM_IRQ]) |=> !statusBits[0]);

  // R8
  disable_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd5) |=> disableBits == $past(regWrData[2*NUM_IRQ +: NUM_IRQ]));

  // R11
  all_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&disableBits) |-> !irqOut);

  // R10
  upper_status_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusBits[NUM_IRQ-1:4] == '0);

endmodule

bind encRingIrq encRingIrqChk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .advValid(advValid), .advBytes(advBytes),
  .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData), .irqOut(irqOut),
  .curPos(curPos), .startAddr(startAddr), .endAddr(endAddr),
  .alertOfs(alertOfs), .statusBits(statusBits), .disableBits(disableBits)
);

// File: tb/sim_encRingIrq.sv
module sim_encRingIrq;
  logic        clk = 1'b0;
  logic        rstN;
  logic        advValid;
  logic [11:0] advBytes;
  logic        regWr;
  logic [2:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        frameSet, ovflSet;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  string focus = "R1";

  // reference state
  logic [23:0] mStart, mEnd, mAp, mAo, mCur;
  logic [7:0]  mStat, mDis;

  always #5ns clk = ~clk;

  encRingIrq u0 (
    .clk(clk), .rstN(rstN), .advValid(advValid), .advBytes(advBytes),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .frameSet(frameSet), .ovflSet(ovflSet),
    .irqOut(irqOut)
  );

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {8'h0, mStart};
      3'd1: return {8'h0, mEnd};
      3'd2: return {8'h0, mAp};
      3'd3: return {8'h0, mAo};
      3'd4: return {8'h0, mCur};
      3'd5: return {8'h0, mDis, 8'h0, mStat};
      default: return 32'h0;
    endcase
  endfunction

  task automatic compareNow();
    logic [31:0] expRd;
    logic expIrq;
    expRd  = modelRead(regAddr);
    expIrq = |(mStat & ~mDis);
    compared++;
    if (regRdData !== expRd) begin
      mismatched++;
      $display("FAIL %s read idx %0d actual %h expected %h", focus, regAddr, regRdData, expRd);
    end
    compared++;
    if (irqOut !== expIrq) begin
      mismatched++;
      $display("FAIL %s/R11 irq actual %b expected %b", focus, irqOut, expIrq);
    end
  endtask

  task automatic modelStep(input logic w, input logic [2:0] a, input logic [31:0] d,
                           input logic adv, input logic [11:0] b,
                           input logic fs, input logic os);
    logic [24:0] sum, tgt;
    logic alert, wrapEv, startWr;
    logic [7:0] ack, setM;
    startWr = w && a == 3'd0;
    tgt   = {1'b0, mAp} + {1'b0, mAo};
    alert = (mAo != 0) && ({1'b0, mCur} >= tgt);
    sum   = {1'b0, mCur} + {13'h0, b};
    wrapEv = adv && !startWr && (sum >= {1'b0, mEnd});
    ack   = (w && a == 3'd5) ? d[15:8] : 8'h0;
    setM  = {4'h0, os, wrapEv, fs, alert && !ack[0]};
    mStat = (mStat & ~ack) | setM;
    if (startWr) mCur = d[23:0];
    else if (adv) mCur = wrapEv ? mStart : sum[23:0];
    if (w) begin
      case (a)
        3'd0: mStart = d[23:0];
        3'd1: mEnd   = d[23:0];
        3'd2: mAp    = d[23:0];
        3'd3: mAo    = d[23:0];
        3'd5: mDis   = d[23:16];
        default: ;
      endcase
    end
  endtask

  // called just after a negedge compare; drives one cycle and compares at next negedge
  task automatic tick(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic adv, input logic [11:0] b,
                      input logic fs, input logic os);
    regWr = w; regAddr = a; regWrData = d; advValid = adv; advBytes = b;
    frameSet = fs; ovflSet = os;
    modelStep(w, a, d, adv, b, fs, os);
    @(posedge clk);
    @(negedge clk);
    compareNow();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    tick(1'b1, a, d, 1'b0, 12'h0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a);
    tick(1'b0, a, 32'h0, 1'b0, 12'h0, 1'b0, 1'b0);
  endtask

  task automatic adv(input logic [11:0] b, input logic [2:0] a);
    tick(1'b0, a, 32'h0, 1'b1, b, 1'b0, 1'b0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R11 actual hung expected finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; advValid = 0; advBytes = 0; regWr = 0; regAddr = 0;
    regWrData = 0; frameSet = 0; ovflSet = 0;
    {mStart, mEnd, mAp, mAo, mCur} = '0; mStat = 0; mDis = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compareNow();

    // R1: reset state and readback with truncation
    focus = "R1";
    for (int i = 0; i < 8; i++) rd(3'(i));
    wr(3'd0, 32'hFF00_0010);
    wr(3'd1, 32'hAB00_0100);
    wr(3'd2, 32'h0000_0080);
    wr(3'd3, 32'h0000_0000);
    for (int i = 0; i < 8; i++) rd(3'(i));

    // R5: pointer slot is read-only
    focus = "R5";
    wr(3'd4, 32'h0000_0055);
    rd(3'd4);

    // R2: plain advances
    focus = "R2";
    adv(12'h020, 3'd4);
    adv(12'h030, 3'd4);
    adv(12'h001, 3'd4);

    // R3: cross the end and fold back
    focus = "R3";
    adv(12'h0A0, 3'd4);
    rd(3'd5);
    adv(12'h0F0, 3'd4);

    // R9: acknowledge wrap, and wrap event racing its acknowledge
    focus = "R9";
    wr(3'd5, 32'h0000_0400);
    rd(3'd5);
    tick(1'b0, 3'd4, 32'h0, 1'b1, 12'h0F0, 1'b0, 1'b0);
    tick(1'b1, 3'd5, 32'h0000_0400, 1'b1, 12'h0F0, 1'b0, 1'b0);
    rd(3'd5);

    // R6: alert level with position plus offset
    focus = "R6";
    wr(3'd5, 32'h0000_FF00);
    wr(3'd2, 32'h0000_0020);
    wr(3'd3, 32'h0000_0010);
    adv(12'h020, 3'd5);
    adv(12'h010, 3'd5);
    rd(3'd5);
    focus = "R9";
    wr(3'd5, 32'h0000_0100);
    rd(3'd5);
    rd(3'd5);
    wr(3'd2, 32'h0000_00F0);
    wr(3'd5, 32'h0000_0100);
    rd(3'd5);

    // R7: zero offset suppresses the alert
    focus = "R7";
    wr(3'd2, 32'h0000_0000);
    wr(3'd3, 32'h0000_0000);
    wr(3'd5, 32'h0000_FF00);
    adv(12'h010, 3'd5);
    rd(3'd5);

    // R10: external events
    focus = "R10";
    tick(1'b0, 3'd5, 32'h0, 1'b0, 12'h0, 1'b1, 1'b0);
    tick(1'b0, 3'd5, 32'h0, 1'b0, 12'h0, 1'b0, 1'b1);
    tick(1'b1, 3'd5, 32'h0000_0200, 1'b0, 12'h0, 1'b1, 1'b0);
    rd(3'd5);

    // R8: disable flags stored and read back
    focus = "R8";
    wr(3'd5, 32'h00FF_0000);
    rd(3'd5);
    wr(3'd5, 32'h00F5_0000);
    rd(3'd5);

    // R11: partial masking
    focus = "R11";
    wr(3'd5, 32'h00FF_FF00);
    tick(1'b0, 3'd5, 32'h0, 1'b0, 12'h0, 1'b1, 1'b0);
    wr(3'd5, 32'h00FD_0000);
    wr(3'd5, 32'h0002_0000);
    rd(3'd5);

    // R4: start write beats a same-cycle advance
    focus = "R4";
    tick(1'b1, 3'd0, 32'h0000_0040, 1'b1, 12'hFFF, 1'b0, 1'b0);
    rd(3'd4);
    rd(3'd5);

    // mixed traffic in a small region
    focus = "RND";
    for (int n = 0; n < 4000; n++) begin
      logic w, ad, fs, os;
      logic [2:0] a;
      logic [31:0] d;
      logic [11:0] b;
      w  = ($urandom_range(0, 9) == 0);
      a  = 3'($urandom_range(0, 7));
      d  = $urandom();
      if (w && a <= 3'd3) d = (a == 3'd1) ? 32'($urandom_range(64, 400))
                                          : 32'($urandom_range(0, 200));
      if (w && a == 3'd3 && $urandom_range(0, 3) == 0) d = 0;
      ad = ($urandom_range(0, 2) == 0);
      b  = 12'($urandom_range(0, 48));
      fs = ($urandom_range(0, 30) == 0);
      os = ($urandom_range(0, 60) == 0);
      tick(w, a, d, ad, b, fs, os);
    end

    finishRun();
  end
endmodule